// File: doc/BRIEF.md
# Four-Function ALU with Condition Flags

This block is a purely combinational arithmetic logic unit. It takes two operand words and a 2-bit function code and returns one result word. The code chooses one of four operations: a sum, a difference, a bitwise AND or a bitwise XOR. The difference takes the first operand away from the second.

Alongside the result, the block drives three condition outputs for whichever operation is selected:

- a zero indication;
- an unsigned carry, which reads as a borrow during subtraction;
- a signed two's-complement overflow.

The block holds no state. Outputs follow any change on the operands or the code without waiting for a clock edge. Storing the flags and testing conditions on them are left to the surrounding logic. The word width is a parameter with a default of 32 bits.

There is no state machine. The selection is one decode of the function code, with a named case for each of the four operations (add, subtract, and, xor) and no transitions.

Top module: `alu4f`

## Requirements
- R1: With function code 0 (add), `result` equals `op_x + op_y` modulo 2^W.
- R2: With function code 1 (subtract), `result` equals `op_y - op_x` modulo 2^W.
- R3: With function code 2 (and), `result` equals the bitwise AND of `op_x` and `op_y`.
- R4: With function code 3 (xor), `result` equals the bitwise XOR of `op_x` and `op_y`.
- R5: For every function code, `flag_zero` is 1 exactly when all W bits of `result` are 0.
- R6: With code 0, `flag_carry` is the carry out of bit W-1 of the unsigned sum.
- R7: With code 1, `flag_carry` is 1 exactly when `op_x` is greater than `op_y` as unsigned numbers (a borrow).
- R8: With code 0, `flag_ovf` is 1 exactly when both operands have the same sign bit and the sign bit of `result` differs from it.
- R9: With code 1, `flag_ovf` is 1 exactly when the sign bits of `op_y` and `op_x` differ and the sign bit of `result` differs from that of `op_y`.
- R10: With code 2 or code 3, `flag_carry` and `flag_ovf` are both 0, whatever the operands.
- R11: The outputs settle to the values of the current inputs with no clock edge in between. A change of operands or of code is seen at the outputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | W | First operand; subtrahend when subtracting |
| op_y | input | W | Second operand; minuend when subtracting |
| func | input | 2 | Operation select: 0 add, 1 subtract, 2 and, 3 xor |
| result | output | W | Result word of the selected operation |
| flag_zero | output | 1 | Result is all zeros |
| flag_carry | output | 1 | Carry out (add) or borrow (subtract); 0 for logic ops |
| flag_ovf | output | 1 | Signed overflow (add, subtract); 0 for logic ops |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Operand order in subtraction.** Equal, larger and smaller operand pairs are used. A design that computes `op_x - op_y` gives a result of the wrong sign and an inverted borrow on those pairs.
- **Carry sense in subtraction.** A design that reports the raw adder carry, instead of its inverse, shows carry 1 when `op_x` is zero or small, which is exactly where no borrow occurs.
- **Overflow at the sign boundary.** Sums and differences that straddle the most negative value are applied. A design that tests the wrong operand's sign, or that forgets the inverted subtrahend, flags overflow on the wrong vectors.
- **Flags for the logic operations.** AND and XOR are applied to all-ones operands. A design that leaks the adder's carry or overflow into those operations raises flags there.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    // Operation codes; the numeric values are the external encoding of func.
    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } alu_fn_e;

    // Condition bundle handed from the selector to the top ports.
    typedef struct packed {
        logic zero;
        logic carry;
        logic ovf;
    } alu_flags_t;

endpackage

// File: rtl/alu4_addsub.sv
// Shared adder: minuend/addend a, second operand b inverted when subtracting.
module alu4_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry_out,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff     = b ^ {W{sub}};
        wide      = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum       = wide[W-1:0];
        carry_out = wide[W];
        // Two inputs of equal sign giving a result of the other sign.
        ovf       = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu4_logic.sv
// Bitwise operations, one bit slice per position.
module alu4_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_out,
    output logic [W-1:0] xor_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign and_out[i] = a[i] & b[i];
        assign xor_out[i] = a[i] ^ b[i];
    end
endmodule

// File: rtl/alu4_select.sv
// Operation decode: picks the result word and shapes the flags.
module alu4_select
    import alu4_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_fn_e      fn,
    input  logic [W-1:0] sum,
    input  logic         carry_out,
    input  logic         arith_ovf,
    input  logic [W-1:0] and_in,
    input  logic [W-1:0] xor_in,
    output logic [W-1:0] res,
    output alu_flags_t   flags
);
    always_comb begin
        res   = '0;
        flags = '0;
        unique case (fn)
            FN_ADD: begin
                res         = sum;
                flags.carry = carry_out;
                flags.ovf   = arith_ovf;
            end
            FN_SUB: begin
                res         = sum;
                flags.carry = ~carry_out;   // no carry out means a borrow
                flags.ovf   = arith_ovf;
            end
            FN_AND: res = and_in;
            FN_XOR: res = xor_in;
            default: res = '0;
        endcase
        flags.zero = ~|res;
    end
endmodule

// File: rtl/alu4f.sv
module alu4f
    import alu4_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic [1:0]   func,
    output logic [W-1:0] result,
    output logic         flag_zero,
    output logic         flag_carry,
    output logic         flag_ovf
);
    alu_fn_e      fn;
    logic [W-1:0] sum_w;
    logic         co_w;
    logic         ov_w;
    logic [W-1:0] and_w;
    logic [W-1:0] xor_w;
    alu_flags_t   flags_w;

    assign fn = alu_fn_e'(func);

    // Second operand is the minuend, so it enters the adder unchanged.
    alu4_addsub #(.W(W)) u_addsub (
        .a         (op_y),
        .b         (op_x),
        .sub       (fn == FN_SUB),
        .sum       (sum_w),
        .carry_out (co_w),
        .ovf       (ov_w)
    );

    alu4_logic #(.W(W)) u_logic (
        .a       (op_x),
        .b       (op_y),
        .and_out (and_w),
        .xor_out (xor_w)
    );

    alu4_select #(.W(W)) u_select (
        .fn        (fn),
        .sum       (sum_w),
        .carry_out (co_w),
        .arith_ovf (ov_w),
        .and_in    (and_w),
        .xor_in    (xor_w),
        .res       (result),
        .flags     (flags_w)
    );

    assign flag_zero  = flags_w.zero;
    assign flag_carry = flags_w.carry;
    assign flag_ovf   = flags_w.ovf;
endmodule

// File: rtl/alu4f_chk.sv
module alu4f_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] op_x,
    input logic [W-1:0] op_y,
    input logic [1:0]   func,
    input logic [W-1:0] result,
    input logic         flag_zero,
    input logic         flag_carry,
    input logic         flag_ovf
);
    localparam int MSB = W - 1;

    always_comb begin
        // R1 and R6: carry and result together form the wide unsigned sum
        if (func == 2'd0)
            assert_add_wide_R6: assert ({flag_carry, result} == ({1'b0, op_x} + {1'b0, op_y}));
        // R2: adding the subtrahend back gives the minuend
        if (func == 2'd1)
            assert_sub_inverse_R2: assert ((result + op_x) == op_y);
        // R7: borrow follows an unsigned comparison
        if (func == 2'd1)
            assert_borrow_R7: assert (flag_carry == (op_x > op_y));
        // R3
        if (func == 2'd2)
            assert_and_bits_R3: assert (((result & ~op_x) == '0) && ((result & ~op_y) == '0)
                                        && ((op_x & op_y & ~result) == '0));
        // R4: XOR is undone by XOR with one operand
        if (func == 2'd3)
            assert_xor_undo_R4: assert ((result ^ op_y) == op_x);
        // R5
        assert_zero_R5: assert (flag_zero == (result == '0));
        // R8
        if (func == 2'd0)
            assert_add_ovf_R8: assert (flag_ovf == ((op_x[MSB] == op_y[MSB]) && (result[MSB] != op_x[MSB])));
        // R9
        if (func == 2'd1)
            assert_sub_ovf_R9: assert (flag_ovf == ((op_x[MSB] != op_y[MSB]) && (result[MSB] != op_y[MSB])));
        // R10
        if (func[1])
            assert_logic_flags_R10: assert (!flag_carry && !flag_ovf);
    end
endmodule

bind alu4f alu4f_chk #(.W(W)) u_chk (
    .op_x       (op_x),
    .op_y       (op_y),
    .func       (func),
    .result     (result),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry),
    .flag_ovf   (flag_ovf)
);

// File: tb/alu4f_tb.sv
module alu4f_tb;
    localparam int W  = 32;
    localparam int NV = 15;
    localparam int VB = 2 * W + 2 + W + 3;

    // Each entry: {x, y, func, expected result, expected {zero, carry, ovf}}
    localparam logic [VB-1:0] VEC [NV] = '{
        {32'h00000001, 32'h00000002, 2'd0, 32'h00000003, 3'b000},
        {32'hFFFFFFFF, 32'h00000001, 2'd0, 32'h00000000, 3'b110},
        {32'h7FFFFFFF, 32'h00000001, 2'd0, 32'h80000000, 3'b001},
        {32'h80000000, 32'h80000000, 2'd0, 32'h00000000, 3'b111},
        {32'h00000003, 32'h00000005, 2'd1, 32'h00000002, 3'b000},
        {32'h00000005, 32'h00000003, 2'd1, 32'hFFFFFFFE, 3'b010},
        {32'h00000005, 32'h00000005, 2'd1, 32'h00000000, 3'b100},
        {32'h00000001, 32'h80000000, 2'd1, 32'h7FFFFFFF, 3'b001},
        {32'h80000000, 32'h00000000, 2'd1, 32'h80000000, 3'b011},
        {32'hF0F0F0F0, 32'hFF00FF00, 2'd2, 32'hF000F000, 3'b000},
        {32'h0F0F0F0F, 32'hF0F0F0F0, 2'd2, 32'h00000000, 3'b100},
        {32'hFFFFFFFF, 32'hFFFFFFFF, 2'd3, 32'h00000000, 3'b100},
        {32'h12345678, 32'hFFFF0000, 2'd3, 32'hEDCB5678, 3'b000},
        {32'hFFFFFFFF, 32'hFFFFFFFF, 2'd2, 32'hFFFFFFFF, 3'b000},
        {32'h00000000, 32'h00000000, 2'd0, 32'h00000000, 3'b100}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] op_x = '0;
    logic [W-1:0] op_y = '0;
    logic [1:0]   func = 2'd0;
    logic [W-1:0] result;
    logic         flag_zero;
    logic         flag_carry;
    logic         flag_ovf;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    alu4f #(.W(W)) u_dut (
        .op_x       (op_x),
        .op_y       (op_y),
        .func       (func),
        .result     (result),
        .flag_zero  (flag_zero),
        .flag_carry (flag_carry),
        .flag_ovf   (flag_ovf)
    );

    task automatic check(input string req, input logic [W-1:0] exp_r, input logic [2:0] exp_f);
        n_checks++;
        if (result !== exp_r || {flag_zero, flag_carry, flag_ovf} !== exp_f) begin
            n_fails++;
            $display("FAIL %s: x=%h y=%h f=%0d got res=%h zco=%b expected res=%h zco=%b",
                     req, op_x, op_y, func, result, {flag_zero, flag_carry, flag_ovf}, exp_r, exp_f);
        end
    endtask

    // Independent model written from the requirements.
    task automatic model(input logic [W-1:0] x, input logic [W-1:0] y, input logic [1:0] f,
                         output logic [W-1:0] r, output logic [2:0] zco);
        logic [W:0] s;
        logic c, o;
        c = 1'b0; o = 1'b0;
        case (f)
            2'd0: begin
                s = {1'b0, x} + {1'b0, y};
                r = s[W-1:0];
                c = s[W];
                o = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
            end
            2'd1: begin
                r = y - x;
                c = (x > y);
                o = (x[W-1] != y[W-1]) && (r[W-1] != y[W-1]);
            end
            2'd2: r = x & y;
            default: r = x ^ y;
        endcase
        zco = {(r == '0), c, o};
    endtask

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [1:0] f);
        @(posedge clk);
        op_x = x; op_y = y; func = f;
        #1;
    endtask

    initial begin
        logic [W-1:0] er;
        logic [2:0]   ef;
        logic [W-1:0] lx;
        logic [W-1:0] ly;

        // Initial state: all-zero inputs give zero result with only zero flag (R1, R5)
        #1;
        check("R5_initial", '0, 3'b100);

        // Table walk covering R1-style sums and the boundaries of R2 to R10
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][VB-1 -: W], VEC[i][VB-1-W -: W], VEC[i][W+4 -: 2]);
            case (VEC[i][W+4 -: 2])
                2'd0: check("R1/R6/R8 table", VEC[i][W+2 -: W], VEC[i][2:0]);
                2'd1: check("R2/R7/R9 table", VEC[i][W+2 -: W], VEC[i][2:0]);
                2'd2: check("R3/R10 table", VEC[i][W+2 -: W], VEC[i][2:0]);
                default: check("R4/R10 table", VEC[i][W+2 -: W], VEC[i][2:0]);
            endcase
        end

        // R11: change inputs with no clock edge between and read at once
        @(negedge clk);
        op_x = 32'h00000010; op_y = 32'h00000020; func = 2'd0;
        #0.5;
        check("R11 add", 32'h00000030, 3'b000);
        func = 2'd1;
        #0.5;
        check("R11 func change", 32'h00000010, 3'b000);
        op_x = 32'h00000020;
        #0.5;
        check("R11 operand change R5", 32'h00000000, 3'b100);

        // Sweep of pseudo-random operands through the model, all four codes
        lx = 32'hACE1_2345;
        ly = 32'h1357_9BDF;
        for (int k = 0; k < 200; k++) begin
            lx = {lx[W-2:0], lx[31] ^ lx[21] ^ lx[1] ^ lx[0]};
            ly = {ly[W-2:0], ly[31] ^ ly[21] ^ ly[1] ^ ly[0]};
            for (int f = 0; f < 4; f++) begin
                apply(lx, (k % 7 == 0) ? lx : ly, 2'(f));
                model(op_x, op_y, func, er, ef);
                check("R1-R10 sweep", er, ef);
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog
    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule